// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a single-cycle-deselect pipelined cache SRAM. Every control, address, byte-select and write-data input is sampled on the rising clock edge. The word fetched by a read goes through one more register stage, so it reaches the output one cycle after the read was captured. Storage is an on-chip array of `2**ADDR_W` words, split into four byte lanes of `LANE_W` bits each.

An access begins on either of two active-low address strobes. The processor strobe `cpu_ads_n` is qualified by `sel0_n` alone, and the access it starts is always a read. The controller strobe `ctl_ads_n` obeys the write controls in its first cycle. After that, `burst_adv_n` moves a 2-bit wrapping burst counter through a linear or an interleaved order. When `burst_adv_n` is high, the counter holds its address. The read or write choice is remade on every cycle from `all_wr_n`, `lane_wr_en_n` and `lane_sel_n`.

The output is modelled as a registered data bus `rd_data` with a drive flag `rd_drive`. The flag is the registered read-valid bit, combined with the asynchronous output enable and with a mask. The mask hides the first read beat that follows a deselected state. The `sleep` input stops all activity and turns the outputs off.

The controller state machine has these states:
- **ST_SLEEP**: sleeping.
- **ST_DESEL**: deselected.
- **ST_RD_FIRST**: a read was captured from the deselected state.
- **ST_READ**: a read was captured.
- **ST_WRITE**: a write was captured.

It has these transitions:
- **go_sleep**: any state to ST_SLEEP while `sleep` is high.
- **wake**: ST_SLEEP to ST_DESEL.
- **start_read**: an accepted strobe with the device selected and no write, to ST_RD_FIRST from ST_DESEL and to ST_READ otherwise.
- **start_write**: the controller strobe with the device selected and a write requested, to ST_WRITE.
- **deselect**: an accepted strobe without full selection, to ST_DESEL.
- **stay_idle**: ST_DESEL to itself when no strobe is accepted.
- **continue**: in an active state with no strobe, advance or hold the address, then go to ST_READ or ST_WRITE according to the write controls.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `rst_n` is low, and after reset until an access occurs, the block is deselected and `rd_drive` is 0.
- R2: A read captured at edge N loads `rd_data` with the addressed word at edge N+1. When the beat is not masked, `rd_drive` is then 1 while `oe_n` is 0.
- R3: `cpu_ads_n` low with `sel0_n` low starts a read at `addr`, whatever the write controls are. It takes priority over `ctl_ads_n`. If `sel1` is 0 or `sel2_n` is 1 at that edge, the cycle is a deselect.
- R4: `ctl_ads_n` low, when the processor strobe is not accepted, starts an access at `addr`. The access is a write in its first cycle if the write controls request one. Without full selection (`sel0_n`=0, `sel1`=1, `sel2_n`=0), the cycle is a deselect and nothing is written.
- R5: `all_wr_n`=0 writes all four lanes, whatever `lane_sel_n` is. Otherwise, `lane_wr_en_n`=0 writes each lane i whose `lane_sel_n[i]` is 0. Lane i is bits `8i+7:8i` of the word when `LANE_W`=8. With `lane_wr_en_n`=0 and `lane_sel_n`=4'hF, the cycle is a read.
- R6: In an active burst with no accepted strobe, `burst_adv_n`=0 steps to the next address. The upper address bits stay fixed. The low two bits of beat k are start+k mod 4 when `lin_burst`=1, and start XOR k when `lin_burst`=0. The sequence wraps after four beats.
- R7: In an active burst with `burst_adv_n`=1 and no accepted strobe, the address is held. The cycle reads or writes that address according to the write controls.
- R8: While deselected with no accepted strobe, the block stays deselected and neither reads nor writes. `rd_drive` is 0 in the cycle after a deselect is captured.
- R9: The first read beat captured from the deselected state has `rd_drive`=0 in its output cycle, even with `oe_n`=0. The following beats are driven normally.
- R10: `oe_n` acts without a clock. `rd_drive` falls and rises with `oe_n` during an unmasked read output cycle.
- R11: While `sleep` is 1, `rd_drive` is 0 and no strobe starts an access or writes. The first edge with `sleep` low only returns the block to the deselected state, and strobes at that edge are ignored.
- R12: The output cycle after a captured write has `rd_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| cpu_ads_n | input | 1 | Processor address strobe, active low |
| ctl_ads_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| wr_data | input | 4*LANE_W | Write data sampled with the write |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| lin_burst | input | 1 | 1 selects linear order, 0 selects interleaved order |
| rd_data | output | 4*LANE_W | Registered read data |
| rd_drive | output | 1 | Output drive flag |

## Verification
The assertions take for granted that `lin_burst` changes only in a cycle where a strobe reloads the burst. They also take for granted that inputs settle away from the clock edge. The stimulus changes the burst order only together with a controller strobe, and it drives every input on the falling edge. The bench fills the whole array with known words before any read, so every beat it compares has a defined expected value. Deselects, sleep and wake cycles are placed between bursts, so that masked first beats and ignored strobes occur under controlled conditions.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_DESEL,
        ST_RD_FIRST,
        ST_READ,
        ST_WRITE
    } pbs_state_t;

    // Low two address bits of burst beat k from a given start.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input logic       lin);
        return lin ? (start + k) : (start ^ k);
    endfunction

endpackage

// File: rtl/pbs_burst_ctr.sv
`timescale 1ns/1ps
module pbs_burst_ctr
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              lin,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        step;

    assign step = cnt_q + 2'd1;

    always_comb begin
        if (load)
            eff_addr = start_addr;
        else if (adv)
            eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step, lin)};
        else
            eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= start_addr;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= step;
        end
    end

endmodule

// File: rtl/pbs_array.sv
`timescale 1ns/1ps
module pbs_array
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] raddr_q;
    logic              re_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr_q <= '0;
            re_q    <= 1'b0;
        end else begin
            re_q <= re;
            if (re)
                raddr_q <= acc_addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && lane_en[g])
                bank[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q <= '0;
            else if (re_q)
                rd_q <= bank[raddr_q];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/pbs_ctrl.sv
`timescale 1ns/1ps
module pbs_ctrl
    import pbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ads_n,
    input  logic             ctl_ads_n,
    input  logic             burst_adv_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             oe_n,
    input  logic             sleep,
    output pbs_state_t       st,
    output logic             ctr_load,
    output logic             ctr_adv,
    output logic             we,
    output logic [LANES-1:0] lane_en,
    output logic             re,
    output logic             rd_drive
);

    pbs_state_t st_q, st_d;
    logic selected, cpu_take, ctl_take, strobe, wr_req;
    logic dvalid_q, mask_q;

    assign selected = !sel0_n && sel1 && !sel2_n;
    assign cpu_take = !cpu_ads_n && !sel0_n;
    assign ctl_take = !ctl_ads_n && !cpu_take;
    assign strobe   = cpu_take || ctl_take;
    assign lane_en  = !all_wr_n ? {LANES{1'b1}} :
                      (!lane_wr_en_n ? ~lane_sel_n : {LANES{1'b0}});
    assign wr_req   = |lane_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_DESEL;
        else
            st_q <= st_d;
    end

    // Next state and cycle decode
    always_comb begin
        st_d     = st_q;
        ctr_load = 1'b0;
        ctr_adv  = 1'b0;
        we       = 1'b0;
        re       = 1'b0;
        if (sleep) begin
            st_d = ST_SLEEP;
        end else begin
            unique case (st_q)
                ST_SLEEP: st_d = ST_DESEL;
                ST_DESEL, ST_RD_FIRST, ST_READ, ST_WRITE: begin
                    if (strobe) begin
                        if (selected) begin
                            ctr_load = 1'b1;
                            if (ctl_take && wr_req) begin
                                we   = 1'b1;
                                st_d = ST_WRITE;
                            end else begin
                                re   = 1'b1;
                                st_d = (st_q == ST_DESEL) ? ST_RD_FIRST : ST_READ;
                            end
                        end else begin
                            st_d = ST_DESEL;
                        end
                    end else if (st_q == ST_DESEL) begin
                        st_d = ST_DESEL;
                    end else begin
                        ctr_adv = !burst_adv_n;
                        if (wr_req) begin
                            we   = 1'b1;
                            st_d = ST_WRITE;
                        end else begin
                            re   = 1'b1;
                            st_d = ST_READ;
                        end
                    end
                end
                default: st_d = ST_DESEL;
            endcase
        end
    end

    // Output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvalid_q <= 1'b0;
            mask_q   <= 1'b0;
        end else begin
            dvalid_q <= (st_q == ST_RD_FIRST || st_q == ST_READ) && !sleep;
            mask_q   <= (st_q == ST_RD_FIRST);
        end
    end

    assign rd_drive = dvalid_q && !mask_q && !oe_n && !sleep;
    assign st       = st_q;

endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cpu_ads_n,
    input  logic                    ctl_ads_n,
    input  logic                    burst_adv_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [3:0]              lane_sel_n,
    input  logic [4*LANE_W-1:0]     wr_data,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    lin_burst,
    output logic [4*LANE_W-1:0]     rd_data,
    output logic                    rd_drive
);

    pbs_state_t        ctrl_st;
    logic              ctr_load, ctr_adv, ctrl_we, ctrl_re;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] eff_addr;

    pbs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_ads_n    (cpu_ads_n),
        .ctl_ads_n    (ctl_ads_n),
        .burst_adv_n  (burst_adv_n),
        .sel0_n       (sel0_n),
        .sel1         (sel1),
        .sel2_n       (sel2_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .oe_n         (oe_n),
        .sleep        (sleep),
        .st           (ctrl_st),
        .ctr_load     (ctr_load),
        .ctr_adv      (ctr_adv),
        .we           (ctrl_we),
        .lane_en      (lane_en),
        .re           (ctrl_re),
        .rd_drive     (rd_drive)
    );

    pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctr_load),
        .adv        (ctr_adv),
        .lin        (lin_burst),
        .start_addr (addr),
        .eff_addr   (eff_addr)
    );

    pbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .lane_en  (lane_en),
        .re       (ctrl_re),
        .acc_addr (eff_addr),
        .wdata    (wr_data),
        .rdata    (rd_data)
    );

endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
module pbs_checker
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              sleep,
    input logic              lin_burst,
    input logic              rd_drive,
    input pbs_state_t        st,
    input logic              we,
    input logic [LANES-1:0]  lane_en,
    input logic              ctr_adv,
    input logic [ADDR_W-1:0] eff_addr
);

    // R2: an unmasked read beat is driven exactly when enabled
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && !sleep) |=> (rd_drive == (!oe_n && !sleep)));

    // R5: a write always touches at least one lane
    p_write_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (lane_en != '0));

    // R6: a linear advance steps the low bits by one, upper bits fixed
    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_adv && lin_burst) |->
            (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1) &&
            (eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

    // R9: first read after deselect is not driven
    p_first_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_FIRST) |=> !rd_drive);

    // R11: no write on the wake edge out of sleep
    p_sleep_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> !we);

    // R12: the cycle after a write is never driven
    p_write_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |=> !rd_drive);

endmodule

bind pipe_burst_sram pbs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .lin_burst (lin_burst),
    .rd_drive  (rd_drive),
    .st        (ctrl_st),
    .we        (ctrl_we),
    .lane_en   (lane_en),
    .ctr_adv   (ctr_adv),
    .eff_addr  (eff_addr)
);

// File: tb/pipe_burst_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb_top;

    localparam int AW = 6;
    localparam int LW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_ads_n = 1'b1, ctl_ads_n = 1'b1, burst_adv_n = 1'b1;
    logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic [31:0]   wr_data = '0;
    logic          oe_n = 1'b0, sleep = 1'b0, lin_burst = 1'b1;
    logic [31:0]   rd_data;
    logic          rd_drive;

    always #2.5 clk = ~clk;

    pipe_burst_sram #(.ADDR_W(AW), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_ads_n(cpu_ads_n),
        .ctl_ads_n(ctl_ads_n), .burst_adv_n(burst_adv_n), .sel0_n(sel0_n),
        .sel1(sel1), .sel2_n(sel2_n), .all_wr_n(all_wr_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep), .lin_burst(lin_burst),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // Behavioural reference
    logic [31:0]   ref_mem [NW];
    int            m_st = 1;          // 0 sleep, 1 deselected, 2 active
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = '0;
    bit            pend_rd = 0, pend_first = 0, e_valid = 0, e_mask = 0;
    logic [31:0]   pend_data = '0, e_data = '0;

    always @(posedge clk) begin
        bit            sel, ptake, ctake, wr;
        logic [3:0]    lanes;
        logic [AW-1:0] a;
        if (!rst_n) begin
            m_st = 1; pend_rd = 0; pend_first = 0; e_valid = 0; e_mask = 0;
        end else begin
            e_valid = pend_rd && !sleep;
            e_mask  = pend_first;
            if (pend_rd) e_data = pend_data;
            pend_rd = 0; pend_first = 0;
            sel   = !sel0_n && sel1 && !sel2_n;
            ptake = !cpu_ads_n && !sel0_n;
            ctake = !ctl_ads_n && !ptake;
            lanes = !all_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_sel_n : 4'h0);
            wr    = (lanes != 4'h0);
            a     = '0;
            if (sleep) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (ptake || ctake) begin
                if (sel) begin
                    m_base = addr; m_k = 0; a = addr;
                    if (ctake && wr) begin
                        for (int i = 0; i < 4; i++)
                            if (lanes[i]) ref_mem[a][8*i +: 8] = wr_data[8*i +: 8];
                    end else begin
                        pend_rd = 1; pend_first = (m_st == 1); pend_data = ref_mem[a];
                    end
                    m_st = 2;
                end else m_st = 1;
            end else if (m_st == 2) begin
                if (!burst_adv_n) m_k = m_k + 2'd1;
                a = {m_base[AW-1:2],
                     lin_burst ? 2'(m_base[1:0] + m_k) : 2'(m_base[1:0] ^ m_k)};
                if (wr) begin
                    for (int i = 0; i < 4; i++)
                        if (lanes[i]) ref_mem[a][8*i +: 8] = wr_data[8*i +: 8];
                end else begin
                    pend_rd = 1; pend_data = ref_mem[a];
                end
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit exp_drv;
        @(posedge clk);
        @(negedge clk);
        exp_drv = e_valid && !e_mask && !oe_n && !sleep;
        check("drive", {31'b0, rd_drive}, {31'b0, exp_drv});
        if (e_valid) check("data", rd_data, e_data);
    endtask

    task automatic idle_in();
        cpu_ads_n = 1; ctl_ads_n = 1; burst_adv_n = 1;
        all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
        sel0_n = 0; sel1 = 1; sel2_n = 0;
    endtask

    task automatic ctl_wr(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic gw, input logic bwe, input logic [3:0] bs);
        idle_in(); ctl_ads_n = 0; addr = a; wr_data = d;
        all_wr_n = gw; lane_wr_en_n = bwe; lane_sel_n = bs;
        tick(); idle_in();
    endtask

    task automatic ctl_rd(input logic [AW-1:0] a);
        idle_in(); ctl_ads_n = 0; addr = a; tick(); idle_in();
    endtask

    task automatic cpu_rd(input logic [AW-1:0] a);
        idle_in(); cpu_ads_n = 0; addr = a; tick(); idle_in();
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            idle_in(); burst_adv_n = 0; tick();
        end
        idle_in();
    endtask

    task automatic desel();
        idle_in(); ctl_ads_n = 0; sel1 = 0; tick(); idle_in();
    endtask

    function automatic logic [31:0] pat(input int i);
        return {8'(i), 8'(~i), 8'(i + 3), 8'(i * 7)};
    endfunction

    initial begin
        // R1: reset
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1; idle_in(); sel1 = 0;
        tick(); tick();

        // R4: controller-strobe writes fill the array
        cur_req = "R4";
        for (int i = 0; i < NW; i++) ctl_wr(AW'(i), pat(i), 1'b0, 1'b1, 4'hF);

        // R12: back-to-back writes leave the bus undriven
        cur_req = "R12";
        ctl_wr(6'd53, 32'hA5A5_0053, 1'b0, 1'b1, 4'hF);
        ctl_wr(6'd54, 32'hA5A5_0054, 1'b0, 1'b1, 4'hF);

        // R8: deselect and stay idle, advance ignored
        cur_req = "R8";
        desel(); tick();
        burst_adv_n = 0; tick(); idle_in(); tick();

        // R9 / R2: processor read from deselect, masked first beat
        cur_req = "R9";
        cpu_rd(6'd12);
        cur_req = "R2";
        lin_burst = 1; adv(3); tick(); tick();

        // R6: interleaved burst with wrap, then linear with wrap
        cur_req = "R6";
        lin_burst = 0; ctl_rd(6'd9); adv(4);
        lin_burst = 1; ctl_rd(6'd22); adv(5);
        lin_burst = 0; ctl_rd(6'd38); adv(3);

        // R5: byte writes, global override, empty lane set reads
        cur_req = "R5";
        lin_burst = 1;
        ctl_wr(6'd30, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
        ctl_wr(6'd30, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'b0111);
        ctl_wr(6'd31, 32'hCAFE_F00D, 1'b0, 1'b0, 4'hE);
        ctl_wr(6'd32, 32'hBAD0_BAD0, 1'b1, 1'b0, 4'hF);
        ctl_rd(6'd30); ctl_rd(6'd31); ctl_rd(6'd32); tick();

        // R3: processor strobe ignores writes, priority and gating
        cur_req = "R3";
        idle_in(); cpu_ads_n = 0; ctl_ads_n = 0; addr = 6'd40;
        all_wr_n = 0; wr_data = 32'h0BAD_0040; tick(); idle_in(); tick();
        idle_in(); sel0_n = 1; cpu_ads_n = 0; ctl_ads_n = 0; addr = 6'd42;
        all_wr_n = 0; wr_data = 32'h0BAD_0042; tick(); idle_in(); tick();
        idle_in(); cpu_ads_n = 0; sel2_n = 1; addr = 6'd43; tick(); idle_in(); tick();
        cpu_rd(6'd44);
        idle_in(); burst_adv_n = 0; all_wr_n = 0; wr_data = 32'h4545_4545; tick();
        idle_in(); lane_wr_en_n = 0; lane_sel_n = 4'b0111; wr_data = 32'h9900_0000; tick();
        idle_in();
        ctl_rd(6'd40); ctl_rd(6'd42); ctl_rd(6'd44); adv(3); tick();

        // R7: suspend holds the address
        cur_req = "R7";
        ctl_rd(6'd50); tick(); tick(); adv(1); tick();
        lane_wr_en_n = 0; lane_sel_n = 4'b1110; wr_data = 32'h0000_00EE; tick();
        idle_in(); tick();

        // R10: output enable acts without a clock
        cur_req = "R10";
        ctl_rd(6'd52);
        oe_n = 1; tick(); tick();
        oe_n = 0; tick();
        #1 oe_n = 1; #0.5 check("drive async", {31'b0, rd_drive}, 32'd0);
        oe_n = 0; #0.5 check("drive async", {31'b0, rd_drive}, 32'd1);
        tick();

        // R11: sleep blocks accesses, wake edge ignored
        cur_req = "R11";
        ctl_rd(6'd55);
        sleep = 1; ctl_ads_n = 0; addr = 6'd56; all_wr_n = 0;
        wr_data = 32'hFFFF_0056; tick(); tick(); tick();
        sleep = 0; addr = 6'd57; wr_data = 32'hFFFF_0057; tick();
        idle_in(); burst_adv_n = 0; tick(); idle_in(); tick();
        cpu_rd(6'd56); ctl_rd(6'd57); tick(); tick();

        desel(); tick(); tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule